// File: doc/BRIEF.md
# Grouped-Priority Preemptive Interrupt Arbiter

This block is the decision core of an interrupt controller for a set of peripheral request lines (32 by default). Each line's rising edge is latched as pending. Every source carries a 5-bit urgency value, and a smaller value is more urgent. A grouping setting divides that value into an upper preemption group and a lower subpriority. Among the pending sources, the block selects the most urgent one. It raises `take_irq` only when that source's group is strictly more urgent than the group of the handler that is running.

On an acknowledge, the winner is pushed onto a nesting stack, which records the source ID and the group it held at that moment. An end-of-interrupt strobe pops the stack. Arbitration then runs again against the group of the handler that was restored. The subpriority and the source index only order requests that are waiting. They never allow one handler to interrupt another.

Top module: `irq_group_arb`

## Requirements
- R1: After reset, nothing is pending, no overflow flag is set, the stack is empty (`act_valid`=0), `take_irq`=0, every source's priority is 0 and the grouping setting is 2.
- R2: A 0-to-1 change on `irq_req[i]` sets `irq_pend[i]` at the next clock edge. A request held high does not set it again. Acceptance of source i clears it.
- R3: A rising edge on a source that is already pending sets `irq_ovf[i]` and leaves one pending request. Acceptance of that source clears `irq_ovf[i]`.
- R4: The candidate is the pending source with the lowest priority value. Ties go to the lowest index. This is the same order as group, then subpriority, then index.
- R5: With grouping setting g (2..7), group = priority >> (g-2) and subpriority = the low g-2 bits. Setting 4 maps values 0..3 to group 0 and 28..31 to group 7. Setting 7 makes every source group 0. Settings 0 and 1 act as 2.
- R6: `take_irq` is 1 only when the candidate's group is strictly lower than the running group. A request in the same group waits, even with a better or identical subpriority.
- R7: When no handler is active, the running group is 32, below every real group, so any pending request gives `take_irq`=1.
- R8: `take_ack` while `take_irq`=1 pushes `take_id` and its group. From the next cycle `act_valid`=1 and `act_id` shows that source.
- R9: `eoi` pops the top entry. `act_id` returns to the previous handler, or `act_valid` goes to 0, and arbitration uses the restored group.
- R10: A priority or grouping write (`cfg_we`, `cfg_grp` selects grouping in `cfg_data[2:0]`, otherwise the priority of `cfg_idx`) affects `take_irq` from the next cycle. Groups already stacked keep the value they had when accepted.
- R11: In a cycle with `eoi`=1, `take_ack` is ignored. `eoi` with an empty stack has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Peripheral request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_grp | input | 1 | 1: write grouping setting, 0: write a priority |
| cfg_idx | input | IDW | Source whose priority is written |
| cfg_data | input | PW | Priority value, or grouping setting in bits [2:0] |
| take_ack | input | 1 | Processor accepts `take_id` |
| eoi | input | 1 | End of the current handler |
| take_irq | output | 1 | A pending source may interrupt now |
| take_id | output | IDW | Candidate source index |
| act_valid | output | 1 | At least one handler is active |
| act_id | output | IDW | Innermost active source |
| irq_pend | output | NSRC | Pending flags |
| irq_ovf | output | NSRC | Merged-request flags |

## Verification
The assertions assume that `take_ack` is raised only after `take_irq` has been seen. They also assume that `eoi` is issued only for a handler that was accepted. An acknowledge or end strobe outside these rules is treated as ignored and is not checked for any other meaning. Every scenario drives requests, strobes and writes at the falling edge and waits for `take_irq` before it acknowledges. A single case deliberately combines `eoi` with `take_ack` on an empty stack, to show that both are ignored.

// File: rtl/irq_group_arb.sv
module irq_group_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 5,
  localparam int IDW   = $clog2(NSRC),
  localparam int DEPTH = 1 << PW,
  localparam int SPW   = $clog2(DEPTH + 1),
  localparam int GW    = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            cfg_we,
  input  logic            cfg_grp,
  input  logic [IDW-1:0]  cfg_idx,
  input  logic [PW-1:0]   cfg_data,
  input  logic            take_ack,
  input  logic            eoi,
  output logic            take_irq,
  output logic [IDW-1:0]  take_id,
  output logic            act_valid,
  output logic [IDW-1:0]  act_id,
  output logic [NSRC-1:0] irq_pend,
  output logic [NSRC-1:0] irq_ovf
);
  localparam logic [2:0] GMIN = 3'(7 - PW);

  logic [NSRC-1:0] req_q, pend_q, ovf_q;
  logic [PW-1:0]   prio_q [NSRC];
  logic [2:0]      grp_q;
  logic [IDW-1:0]  stk_id  [DEPTH];
  logic [GW-1:0]   stk_grp [DEPTH];
  logic [SPW-1:0]  sp;

  logic            any;
  logic [IDW-1:0]  best_id;
  logic [PW-1:0]   best_p;

  wire [NSRC-1:0] rise   = irq_req & ~req_q;
  wire [2:0]      shf    = ((grp_q < GMIN) ? GMIN : grp_q) - GMIN;
  wire [GW-1:0]   win_g  = GW'(best_p >> shf);
  wire [PW-1:0]   top_ix = PW'(sp - 1'b1);
  wire [GW-1:0]   run_g  = (sp == '0) ? GW'(DEPTH) : stk_grp[top_ix];
  wire            acc    = take_ack & take_irq & ~eoi;
  wire            pop    = eoi & (sp != '0);
  wire [NSRC-1:0] clr    = acc ? (NSRC'(1) << best_id) : '0;

  always_comb begin
    any     = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < NSRC; i++)
      if (pend_q[i] && (!any || prio_q[i] < best_p)) begin
        any     = 1'b1;
        best_id = IDW'(i);
        best_p  = prio_q[i];
      end
  end

  assign take_irq  = any && (win_g < run_g);
  assign take_id   = best_id;
  assign act_valid = (sp != '0);
  assign act_id    = stk_id[top_ix];
  assign irq_pend  = pend_q;
  assign irq_ovf   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      ovf_q  <= '0;
      grp_q  <= GMIN;
      sp     <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_id[i]  <= '0;
        stk_grp[i] <= '0;
      end
    end else begin
      req_q  <= irq_req;
      pend_q <= (pend_q & ~clr) | rise;
      ovf_q  <= (ovf_q & ~clr) | (rise & pend_q & ~clr);
      if (cfg_we) begin
        if (cfg_grp) grp_q <= cfg_data[2:0];
        else if (int'(cfg_idx) < NSRC) prio_q[cfg_idx] <= cfg_data;
      end
      if (pop) sp <= sp - 1'b1;
      else if (acc) begin
        stk_id[PW'(sp)]  <= best_id;
        stk_grp[PW'(sp)] <= win_g;
        sp               <= sp + 1'b1;
      end
    end
  end

  // R2
  take_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> pend_q[take_id]);
  // R3
  ovf_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q & ~pend_q) == '0);
  // R6
  stk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp >= SPW'(2)) |-> (stk_grp[top_ix] < stk_grp[PW'(sp - SPW'(2))]));
  // R6
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  // R8
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> act_valid && act_id == $past(take_id));
  // R9
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp == $past(sp) - 1'b1);
  // R11
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && take_ack && sp == '0) |=> !act_valid);
endmodule

// File: tb/irq_group_arb_tb_top.sv
module irq_group_arb_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [31:0] irq_req = '0;
  logic        cfg_we = 0, cfg_grp = 0, take_ack = 0, eoi = 0;
  logic [4:0]  cfg_idx = '0, cfg_data = '0;
  logic        take_irq, act_valid;
  logic [4:0]  take_id, act_id;
  logic [31:0] irq_pend, irq_ovf;
  int n = 0, bad = 0;

  always #5 clk = ~clk;

  irq_group_arb dut_i (.clk, .rst_n, .irq_req, .cfg_we, .cfg_grp, .cfg_idx,
    .cfg_data, .take_ack, .eoi, .take_irq, .take_id, .act_valid, .act_id,
    .irq_pend, .irq_ovf);

  task step; @(posedge clk); @(negedge clk); endtask
  task chk(string tag, int act, int exp);
    n++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task reset_all;
    rst_n = 0; irq_req = '0; cfg_we = 0; take_ack = 0; eoi = 0;
    step; step; rst_n = 1; step;
  endtask
  task fire(logic [31:0] m); irq_req |= m; step; irq_req &= ~m; endtask
  task ack; take_ack = 1; step; take_ack = 0; endtask
  task done; eoi = 1; step; eoi = 0; endtask
  task setp(int i, int v);
    cfg_we = 1; cfg_grp = 0; cfg_idx = 5'(i); cfg_data = 5'(v); step; cfg_we = 0;
  endtask
  task setg(int v);
    cfg_we = 1; cfg_grp = 1; cfg_data = 5'(v); step; cfg_we = 0;
  endtask

  task t_reset;
    reset_all;
    chk("R1 pend", int'(irq_pend), 0);
    chk("R1 ovf", int'(irq_ovf), 0);
    chk("R1 act_valid", int'(act_valid), 0);
    chk("R1 take_irq", int'(take_irq), 0);
    fire(32'h28);
    chk("R1 equal default prio, R4 index", int'(take_id), 3);
  endtask

  task t_pend;
    reset_all;
    irq_req[9] = 1; step;
    chk("R2 pend set", int'(irq_pend[9]), 1);
    chk("R7 idle take", int'(take_irq), 1);
    chk("R7 id", int'(take_id), 9);
    ack;
    chk("R2 cleared on accept", int'(irq_pend[9]), 0);
    chk("R8 act_valid", int'(act_valid), 1);
    chk("R8 act_id", int'(act_id), 9);
    step;
    chk("R2 held level no reset", int'(irq_pend[9]), 0);
    irq_req[9] = 0;
    done;
    chk("R9 pop to idle", int'(act_valid), 0);
  endtask

  task t_ovf;
    reset_all;
    fire(32'h10); step; fire(32'h10);
    chk("R3 ovf set", int'(irq_ovf[4]), 1);
    chk("R3 still pending", int'(irq_pend[4]), 1);
    ack;
    chk("R3 ovf cleared", int'(irq_ovf[4]), 0);
    chk("R3 pend cleared", int'(irq_pend[4]), 0);
  endtask

  task t_order;
    reset_all;
    setp(2, 7); setp(6, 3); setp(10, 3);
    fire(32'h444);
    chk("R4 lowest value then index", int'(take_id), 6);
    ack;
    chk("R6 identical prio waits", int'(take_irq), 0);
    done;
    chk("R9 rearbitrate take", int'(take_irq), 1);
    chk("R9 rearbitrate id", int'(take_id), 10);
  endtask

  task t_group;
    reset_all;
    setg(4); setp(8, 6); fire(32'h100); ack;
    setp(2, 4); fire(32'h4);
    chk("R6 better sub same group waits", int'(take_irq), 0);
    setp(3, 3); fire(32'h8);
    chk("R5 group0 preempts", int'(take_irq), 1);
    chk("R5 id", int'(take_id), 3);
    ack;
    chk("R8 nested act_id", int'(act_id), 3);
    done;
    chk("R9 restored act_id", int'(act_id), 8);
    chk("R9 restored group blocks", int'(take_irq), 0);
    done;
    chk("R9 idle then take", int'(take_id), 2);
    chk("R9 idle take_irq", int'(take_irq), 1);
  endtask

  task t_split;
    reset_all;
    setg(4); setp(1, 28); setp(2, 31); setp(3, 27);
    fire(32'h2); ack; fire(32'h4);
    chk("R5 28 and 31 same group", int'(take_irq), 0);
    fire(32'h8);
    chk("R5 27 preempts 28", int'(take_irq), 1);
    reset_all;
    setg(7); setp(1, 31); fire(32'h2); ack; fire(32'h4);
    chk("R5 setting 7 single group", int'(take_irq), 0);
    reset_all;
    setg(1); setp(1, 5); setp(2, 4); fire(32'h2); ack; fire(32'h4);
    chk("R5 setting 1 acts as 2", int'(take_irq), 1);
  endtask

  task t_cfg;
    reset_all;
    setp(1, 8); fire(32'h2); ack;
    setp(2, 9); fire(32'h4);
    chk("R10 blocked", int'(take_irq), 0);
    cfg_we = 1; cfg_grp = 0; cfg_idx = 5'd2; cfg_data = 5'd7; #1;
    chk("R10 not before edge", int'(take_irq), 0);
    step; cfg_we = 0;
    chk("R10 next cycle", int'(take_irq), 1);
    setp(2, 9); setp(1, 31);
    chk("R10 stacked group kept", int'(take_irq), 0);
    chk("R10 act_id", int'(act_id), 1);
  endtask

  task t_both;
    reset_all;
    fire(32'h80);
    take_ack = 1; eoi = 1; step; take_ack = 0; eoi = 0;
    chk("R11 ack ignored pend", int'(irq_pend[7]), 1);
    chk("R11 empty eoi no push", int'(act_valid), 0);
  endtask

  initial begin
    t_reset; t_pend; t_ovf; t_order; t_group; t_split; t_cfg; t_both;
    $display("test done: total=%0d bad=%0d", n, bad);
    $finish;
  end

  initial begin
    #1500000;
    n++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n, bad);
    $finish;
  end
endmodule